// File: doc/BRIEF.md
# Cache Maintenance Sequencer

This block executes maintenance commands against the tag and data storage of a two-way, set-associative data cache with 64-byte lines. A command is an opcode, a byte address and a 32-bit tag/data transfer value. The unit either looks the address up in both ways and acts on the way that holds it (hit-type), or acts on the way named by address bit 0 (index-type). Commands can invalidate a line, write a dirty line back to memory, do both, move one data word into or out of the transfer register, read a line's flag field, or overwrite a line's flags.

Write-back streams the line to memory one 32-bit word per cycle on a simple valid/address/data port. A single line-action path serves both command families. Invalidation keeps the replacement-history bit, so victim choice is unaffected by maintenance. The controller walks through the states IDLE, PICK, DRAIN, WIPE and DONE. The transitions are IDLE→PICK on an accepted command. From PICK it goes to DRAIN when a write-back is needed, to WIPE for an invalidate without write-back, and to DONE otherwise or on a miss. DRAIN→WIPE or DRAIN→DONE happens after the last word. WIPE→DONE and DONE→IDLE follow unconditionally.

Top module: `cmo_unit`

## Requirements
- R1: After reset, busy, done and wb_valid are 0 and every tag entry and data word reads as 0.
- R2: Opcode map: 0x1A hit invalidate, 0x18 hit write-back+invalidate, 0x1C hit write-back, 0x16 index invalidate, 0x14 index write-back+invalidate, 0x11 index load word, 0x13 index store word, 0x10 index load flags, 0x12 index store flags. Any other opcode completes with done two cycles after acceptance and changes nothing.
- R3: A hit-type command matches a way whose valid flag (bit 5) is set and whose tag bits [31:12] equal address bits [31:12]. Way 0 wins if both match. On no match the command does nothing.
- R4: Index-type commands select the set with address bits [11:6] and the way with address bit 0.
- R5: Write-back happens only when dirty (bit 6) and valid (bit 5) are both set. It emits 16 consecutive beats from word 0 to word 15, at wb_addr = {tag[31:12], set, word, 2'b00}, then clears dirty.
- R6: Invalidate reduces the tag entry to its replacement-history bit (bit 4) alone and zeroes all 16 data words of the line.
- R7: Write-back+invalidate performs the conditional write-back of R5 first and then the clear of R6.
- R8: Load word returns the data word chosen by address bits [5:2] on taglo_out. Store word writes taglo_in to that word.
- R9: Load flags first performs the conditional write-back of R5. It then returns the 12-bit flag field in taglo_out[11:0], with bits [31:12] zero.
- R10: Store flags replaces tag bits [11:0] with taglo_in[11:0] and leaves tag bits [31:12] unchanged.
- R11: busy rises the cycle after acceptance and stays high until done. done is a one-cycle pulse 2 + beats + (1 if a clear happens) cycles after acceptance. A command presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present; taken only when busy is low |
| cmd_op | input | 5 | Maintenance opcode |
| cmd_addr | input | 32 | Byte address of the command |
| taglo_in | input | 32 | Transfer register value for store commands |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| taglo_out | output | 32 | Transfer register result of load commands |
| wb_valid | output | 1 | Write-back beat present |
| wb_addr | output | 32 | Byte address of the write-back beat |
| wb_data | output | 32 | Data of the write-back beat |

## Verification
Two things can coincide in one cycle. A new command can arrive while a write-back stream is in progress, and the last write-back beat is also the cycle in which the dirty flag is cleared and the path to WIPE is taken. The bench injects a store-flags command to an unrelated set in the middle of a 16-beat drain. It then reads that set's flags back and expects them unchanged. A behavioural model compares every beat, the busy and done timing, and the flags read after the drain and after the following clear.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
    localparam int OP_W      = 5;
    localparam int FLAG_W    = 12;
    localparam int DIRTY_BIT = 6;
    localparam int VALID_BIT = 5;
    localparam int HIST_BIT  = 4;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_INV, ACT_WB, ACT_WBINV,
        ACT_LDWORD, ACT_LDFLAGS, ACT_STWORD, ACT_STFLAGS
    } act_e;

    typedef struct packed {
        logic by_hit;
        act_e act;
    } ctl_t;

    typedef enum logic [2:0] {
        S_IDLE, S_PICK, S_DRAIN, S_WIPE, S_DONE
    } state_e;
endpackage

// File: rtl/cmo_decode.sv
module cmo_decode
    import cmo_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output ctl_t            ctl
);
    always_comb begin
        ctl = '{by_hit: 1'b0, act: ACT_NONE};
        unique case (op)
            5'h1A:   ctl = '{by_hit: 1'b1, act: ACT_INV};
            5'h18:   ctl = '{by_hit: 1'b1, act: ACT_WBINV};
            5'h1C:   ctl = '{by_hit: 1'b1, act: ACT_WB};
            5'h16:   ctl = '{by_hit: 1'b0, act: ACT_INV};
            5'h14:   ctl = '{by_hit: 1'b0, act: ACT_WBINV};
            5'h11:   ctl = '{by_hit: 1'b0, act: ACT_LDWORD};
            5'h13:   ctl = '{by_hit: 1'b0, act: ACT_STWORD};
            5'h10:   ctl = '{by_hit: 1'b0, act: ACT_LDFLAGS};
            5'h12:   ctl = '{by_hit: 1'b0, act: ACT_STFLAGS};
            default: ctl = '{by_hit: 1'b0, act: ACT_NONE};
        endcase
    end
endmodule

// File: rtl/cmo_match.sv
module cmo_match #(
    parameter int HI_W = 20
) (
    input  logic [HI_W-1:0] hi0,
    input  logic            vld0,
    input  logic [HI_W-1:0] hi1,
    input  logic            vld1,
    input  logic [HI_W-1:0] probe,
    output logic            hit,
    output logic            way
);
    logic m0, m1;
    assign m0  = vld0 && (hi0 == probe);
    assign m1  = vld1 && (hi1 == probe);
    assign hit = m0 || m1;
    assign way = !m0 && m1;
endmodule

// File: rtl/cmo_arrays.sv
module cmo_arrays #(
    parameter int SETS  = 64,
    parameter int WORDS = 16,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int SB   = $clog2(SETS),
    localparam int WB   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SB-1:0] set,
    input  logic          way,
    input  logic [WB-1:0] word,
    output logic [AW-1:0] tag0,
    output logic [AW-1:0] tag1,
    output logic [AW-1:0] rd_tag,
    output logic [DW-1:0] rd_word,
    input  logic          tag_we,
    input  logic [AW-1:0] tag_wd,
    input  logic          word_we,
    input  logic [DW-1:0] word_wd,
    input  logic          wipe
);
    logic [AW-1:0] tag_mem [SETS][2];
    logic [DW-1:0] dat_mem [SETS][2][WORDS];

    assign tag0    = tag_mem[set][0];
    assign tag1    = tag_mem[set][1];
    assign rd_tag  = tag_mem[set][way];
    assign rd_word = dat_mem[set][way][word];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < 2; w++) begin
                    tag_mem[s][w] <= '0;
                    for (int k = 0; k < WORDS; k++) dat_mem[s][w][k] <= '0;
                end
            end
        end else begin
            if (tag_we) tag_mem[set][way] <= tag_wd;
            if (word_we) dat_mem[set][way][word] <= word_wd;
            if (wipe) begin
                for (int k = 0; k < WORDS; k++) dat_mem[set][way][k] <= '0;
            end
        end
    end
endmodule

// File: rtl/cmo_unit.sv
module cmo_unit
    import cmo_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int WORDS = 16,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [DW-1:0]   taglo_in,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   taglo_out,
    output logic            wb_valid,
    output logic [AW-1:0]   wb_addr,
    output logic [DW-1:0]   wb_data
);
    localparam int BB   = $clog2(DW / 8);
    localparam int WB   = $clog2(WORDS);
    localparam int SB   = $clog2(SETS);
    localparam int OFFB = WB + BB;
    localparam int IDXH = OFFB + SB;
    localparam logic [WB-1:0] LAST = WB'(WORDS - 1);

    state_e          st, nxt;
    logic [OP_W-1:0] op_q;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   tlo_q;
    logic            way_q;
    logic [WB-1:0]   cnt_q;
    logic [DW-1:0]   tlo_out_q;

    ctl_t            ctl;
    logic [AW-1:0]   tag0, tag1, cur_tag;
    logic [DW-1:0]   rd_word;
    logic            m_hit, m_way, way_c, sel_way, act_ok, needs_wb, wipe_after, last_beat;
    logic            tag_we, word_we, wipe;
    logic [AW-1:0]   tag_wd;
    logic [WB-1:0]   word_sel;
    logic [SB-1:0]   set_q;
    logic            unused_bits;

    assign set_q       = addr_q[IDXH-1:OFFB];
    assign unused_bits = ^addr_q[BB-1:1];

    cmo_decode u_dec (.op(op_q), .ctl(ctl));

    cmo_match #(.HI_W(AW - FLAG_W)) u_match (
        .hi0(tag0[AW-1:FLAG_W]), .vld0(tag0[VALID_BIT]),
        .hi1(tag1[AW-1:FLAG_W]), .vld1(tag1[VALID_BIT]),
        .probe(addr_q[AW-1:FLAG_W]), .hit(m_hit), .way(m_way)
    );

    assign way_c      = ctl.by_hit ? m_way : addr_q[0];
    assign sel_way    = (st == S_PICK) ? way_c : way_q;
    assign act_ok     = !ctl.by_hit || m_hit;
    assign needs_wb   = act_ok && cur_tag[DIRTY_BIT] && cur_tag[VALID_BIT] &&
                        (ctl.act inside {ACT_WB, ACT_WBINV, ACT_LDFLAGS});
    assign wipe_after = act_ok && (ctl.act inside {ACT_INV, ACT_WBINV});
    assign last_beat  = (cnt_q == LAST);
    assign word_sel   = (st == S_DRAIN) ? cnt_q : addr_q[OFFB-1:BB];

    cmo_arrays #(.SETS(SETS), .WORDS(WORDS), .AW(AW), .DW(DW)) u_arr (
        .clk(clk), .rst_n(rst_n), .set(set_q), .way(sel_way), .word(word_sel),
        .tag0(tag0), .tag1(tag1), .rd_tag(cur_tag), .rd_word(rd_word),
        .tag_we(tag_we), .tag_wd(tag_wd), .word_we(word_we), .word_wd(tlo_q),
        .wipe(wipe)
    );

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:  if (cmd_valid) nxt = S_PICK;
            S_PICK:  if (needs_wb) nxt = S_DRAIN;
                     else if (wipe_after) nxt = S_WIPE;
                     else nxt = S_DONE;
            S_DRAIN: if (last_beat) nxt = wipe_after ? S_WIPE : S_DONE;
            S_WIPE:  nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register and command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            op_q      <= '0;
            addr_q    <= '0;
            tlo_q     <= '0;
            way_q     <= 1'b0;
            cnt_q     <= '0;
            tlo_out_q <= '0;
        end else begin
            st <= nxt;
            unique case (st)
                S_IDLE: if (cmd_valid) begin
                    op_q   <= cmd_op;
                    addr_q <= cmd_addr;
                    tlo_q  <= taglo_in;
                end
                S_PICK: begin
                    way_q <= way_c;
                    cnt_q <= '0;
                    if (act_ok && ctl.act == ACT_LDWORD) tlo_out_q <= rd_word;
                    if (act_ok && ctl.act == ACT_LDFLAGS && !needs_wb)
                        tlo_out_q <= {{(DW-FLAG_W){1'b0}}, cur_tag[FLAG_W-1:0]};
                end
                S_DRAIN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last_beat && ctl.act == ACT_LDFLAGS) begin
                        tlo_out_q <= {{(DW-FLAG_W){1'b0}}, cur_tag[FLAG_W-1:0]};
                        tlo_out_q[DIRTY_BIT] <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs and array controls
    always_comb begin
        busy     = (st != S_IDLE);
        done     = (st == S_DONE);
        wb_valid = (st == S_DRAIN);
        wb_addr  = {cur_tag[AW-1:IDXH], set_q, cnt_q, {BB{1'b0}}};
        wb_data  = rd_word;
        tag_we   = 1'b0;
        tag_wd   = cur_tag;
        word_we  = 1'b0;
        wipe     = 1'b0;
        unique case (st)
            S_PICK: begin
                if (ctl.act == ACT_STFLAGS) begin
                    tag_we = 1'b1;
                    tag_wd = {cur_tag[AW-1:FLAG_W], tlo_q[FLAG_W-1:0]};
                end
                word_we = (ctl.act == ACT_STWORD);
            end
            S_DRAIN: if (last_beat) begin
                tag_we            = 1'b1;
                tag_wd[DIRTY_BIT] = 1'b0;
            end
            S_WIPE: begin
                tag_we           = 1'b1;
                tag_wd           = '0;
                tag_wd[HIST_BIT] = cur_tag[HIST_BIT];
                wipe             = 1'b1;
            end
            default: ;
        endcase
    end

    assign taglo_out = tlo_out_q;
endmodule

// File: rtl/cmo_unit_chk.sv
module cmo_unit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          busy,
    input logic          done,
    input logic          wb_valid,
    input logic [AW-1:0] wb_addr
);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);
    // R11
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R5
    beat_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (busy && !done));
    // R5
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && $past(wb_valid)) |-> (wb_addr == $past(wb_addr) + AW'(4)));
    // R5
    beat_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_valid) |-> (wb_addr[5:2] == 4'd0));
endmodule

bind cmo_unit cmo_unit_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
    .done(done), .wb_valid(wb_valid), .wb_addr(wb_addr)
);

// File: tb/cmo_unit_tb.sv
module cmo_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [4:0]  cmd_op = '0;
    logic [31:0] cmd_addr = '0;
    logic [31:0] taglo_in = '0;
    logic        busy, done, wb_valid;
    logic [31:0] taglo_out, wb_addr, wb_data;

    int nchk = 0;
    int nerr = 0;

    logic [31:0] mt [64][2];
    logic [31:0] md [64][2][16];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmo_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .taglo_in(taglo_in), .busy(busy), .done(done),
        .taglo_out(taglo_out), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    task automatic check(input bit c, input string rq, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (!c) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, got, exp);
        end
    endtask

    function automatic logic [31:0] la(input int set, input int word, input int way);
        logic [5:0] s6 = 6'(set);
        logic [3:0] w4 = 4'(word);
        return {20'h0, s6, w4, 1'b0, 1'(way)};
    endfunction

    task automatic run(input logic [4:0] op, input logic [31:0] a, input logic [31:0] t,
                       input bit inject, input string rq);
        int s, w, act, nb, lat;
        bit byhit, ok, clr, chk_t;
        logic [31:0] expt;
        logic [31:0] qa[$];
        logic [31:0] qd[$];
        s = int'(a[11:6]);
        byhit = 0; act = 0; chk_t = 0; expt = '0;
        case (op)
            5'h1A: begin byhit = 1; act = 1; end
            5'h18: begin byhit = 1; act = 3; end
            5'h1C: begin byhit = 1; act = 2; end
            5'h16: act = 1;
            5'h14: act = 3;
            5'h11: act = 4;
            5'h10: act = 5;
            5'h13: act = 6;
            5'h12: act = 7;
            default: act = 0;
        endcase
        if (byhit) begin
            if (mt[s][0][5] && mt[s][0][31:12] == a[31:12]) begin ok = 1; w = 0; end
            else if (mt[s][1][5] && mt[s][1][31:12] == a[31:12]) begin ok = 1; w = 1; end
            else begin ok = 0; w = 0; end
        end else begin
            ok = 1; w = int'(a[0]);
        end
        if (ok && (act == 2 || act == 3 || act == 5) && mt[s][w][6] && mt[s][w][5]) begin
            for (int j = 0; j < 16; j++) begin
                qa.push_back({mt[s][w][31:12], 6'(s), 4'(j), 2'b00});
                qd.push_back(md[s][w][j]);
            end
            mt[s][w][6] = 1'b0;
        end
        clr = ok && (act == 1 || act == 3);
        if (clr) begin
            mt[s][w] = mt[s][w] & 32'h10;
            for (int j = 0; j < 16; j++) md[s][w][j] = '0;
        end
        if (ok && act == 4) begin chk_t = 1; expt = md[s][w][a[5:2]]; end
        if (ok && act == 5) begin chk_t = 1; expt = {20'h0, mt[s][w][11:0]}; end
        if (ok && act == 6) md[s][w][a[5:2]] = t;
        if (ok && act == 7) mt[s][w][11:0] = t[11:0];
        nb  = qa.size();
        lat = 2 + nb + int'(clr);

        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; taglo_in = t;
        for (int k = 1; k <= lat; k++) begin
            bit ew, ed, good;
            @(negedge clk);
            if (k == 1 || k == 5) cmd_valid = 1'b0;
            if (inject && k == 4) begin
                cmd_valid = 1'b1; cmd_op = 5'h12; cmd_addr = la(20, 0, 0); taglo_in = 32'hFFF;
            end
            ew = (k >= 2) && (k < 2 + nb);
            ed = (k == lat);
            good = busy && (done == ed) && (wb_valid == ew);
            if (good && ew) good = (wb_addr == qa[k-2]) && (wb_data == qd[k-2]);
            check(good, rq, $sformatf("cycle %0d busy/done/beat", k),
                  {busy, done, wb_valid, wb_addr[28:0]},
                  {1'b1, ed, ew, (ew ? qa[k-2][28:0] : 29'h0)});
        end
        if (chk_t) check(taglo_out == expt, rq, "taglo_out", taglo_out, expt);
        @(negedge clk);
        check(!busy && !done && !wb_valid, "R11", "idle after done",
              {29'h0, busy, done, wb_valid}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int s = 0; s < 64; s++)
            for (int w = 0; w < 2; w++) begin
                mt[s][w] = '0;
                for (int j = 0; j < 16; j++) md[s][w][j] = '0;
            end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !wb_valid, "R1", "outputs in reset",
              {29'h0, busy, done, wb_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !wb_valid, "R1", "outputs after reset",
              {29'h0, busy, done, wb_valid}, 32'h0);
        run(5'h10, la(5, 0, 1), 0, 0, "R1");                 // flags read zero
        run(5'h11, la(5, 9, 1), 0, 0, "R1");                 // data reads zero

        // R8/R4: word store and load, way and word select
        for (int j = 0; j < 16; j++) run(5'h13, la(3, j, 1), 32'hA500_0000 + j, 0, "R8");
        run(5'h11, la(3, 7, 1), 0, 0, "R8");
        run(5'h11, la(3, 7, 0), 0, 0, "R4");                 // other way untouched
        run(5'h11, la(4, 7, 1), 0, 0, "R4");                 // other set untouched

        // R10/R9/R5: flags dirty+valid+hist, load flags drains first
        run(5'h12, la(3, 0, 1), 32'hFFFF_F070, 0, "R10");
        run(5'h10, la(3, 0, 1), 0, 0, "R9");
        run(5'h10, la(3, 0, 1), 0, 0, "R9");                 // clean now: no beats

        // R3/R5: hit write-back on way 1, then clean hit does nothing; stray cmd while busy
        run(5'h12, la(3, 0, 1), 32'h060, 0, "R10");
        run(5'h1C, la(3, 0, 0), 0, 1, "R11");
        run(5'h10, la(20, 0, 0), 0, 0, "R11");               // injected command ignored
        run(5'h1C, la(3, 0, 0), 0, 0, "R5");
        run(5'h1A, 32'h0000_10C0, 0, 0, "R3");               // tag mismatch: miss
        run(5'h10, la(3, 0, 1), 0, 0, "R3");

        // R7/R6: hit write-back+invalidate keeps hist bit
        run(5'h12, la(3, 0, 1), 32'h070, 0, "R10");
        run(5'h18, la(3, 0, 0), 0, 0, "R7");
        run(5'h10, la(3, 0, 1), 0, 0, "R6");
        run(5'h11, la(3, 7, 1), 0, 0, "R6");

        // R3: both ways valid, way 0 wins
        run(5'h13, la(9, 2, 0), 32'h1111_0000, 0, "R8");
        run(5'h13, la(9, 2, 1), 32'h2222_0000, 0, "R8");
        run(5'h12, la(9, 0, 0), 32'h020, 0, "R10");
        run(5'h12, la(9, 0, 1), 32'h020, 0, "R10");
        run(5'h1A, la(9, 0, 0), 0, 0, "R3");
        run(5'h10, la(9, 0, 0), 0, 0, "R3");
        run(5'h10, la(9, 0, 1), 0, 0, "R3");
        run(5'h11, la(9, 2, 1), 0, 0, "R3");

        // R6: index invalidate, hist and lock set
        run(5'h12, la(10, 0, 0), 32'h078, 0, "R10");
        run(5'h16, la(10, 0, 0), 0, 0, "R6");
        run(5'h10, la(10, 0, 0), 0, 0, "R6");

        // R7: index write-back+invalidate on dirty line
        for (int j = 0; j < 16; j++) run(5'h13, la(11, j, 1), 32'h0BAD_0000 ^ (j << 8), 0, "R8");
        run(5'h12, la(11, 0, 1), 32'h060, 0, "R10");
        run(5'h14, la(11, 0, 1), 0, 0, "R7");
        run(5'h11, la(11, 15, 1), 0, 0, "R7");

        // R2: undefined opcode, then state intact
        run(5'h12, la(12, 0, 0), 32'h064, 0, "R10");
        run(5'h05, la(12, 0, 0), 32'hFFFF_FFFF, 0, "R2");
        run(5'h1F, la(12, 0, 0), 32'hFFFF_FFFF, 0, "R2");
        run(5'h10, la(12, 0, 0), 0, 0, "R2");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule